// File: doc/BRIEF.md
# Prefetch Issue Buffer with Shared-to-Exclusive Upgrade

This block is a small ordered queue between a processor's prefetch requests and the memory system. Each request carries a byte address and a kind bit, shared or exclusive. When the block accepts a request, it sends the line address to the primary cache tag array. The hit/miss answer comes back one cycle later. A request that hits is dropped at that point, so it costs only the tag lookup. A request that misses is compared with the lines already waiting in the queue. It is then discarded as redundant, merged into a waiting shared entry by upgrading that entry to exclusive, or given a new entry.

Entries leave in arrival order over a valid/ready handshake toward memory. An entry counts as sent from the first cycle it is offered on that port. Its payload is frozen from then on, so a later exclusive request for the same line gets its own entry and is not folded into it. When there is no room, the block lowers its ready signal and the processor waits. A prefetch is never lost to a full queue.

Top module: `pf_issue_buf`

## Requirements
- R1: On the first cycle after synchronous reset is released, the memory port is idle (`mem_valid` low) and `pf_ready` is high.
- R2: Requests are compared at line granularity: `tag_line` and `mem_line` are the address with its low log2(LINE_BYTES) offset bits removed, and two addresses that differ only in those bits name the same line.
- R3: An accepted request drives `tag_lookup` high in its acceptance cycle. If `tag_hit` is high one cycle later, that request never reaches the memory port.
- R4: `pf_ready` is low whenever occupied entries plus a request awaiting its tag answer equal DEPTH. The block never allocates beyond DEPTH entries, and every missing, non-redundant request is eventually issued.
- R5: An exclusive request (`pf_excl`=1) for a line held by a shared entry that has not yet been offered to memory turns that entry exclusive in place. The entry keeps its queue position and no second entry is made.
- R6: An exclusive request for a line whose shared entry is already being offered, or was already accepted, by memory gets a new entry that is issued after it.
- R7: A request whose line and kind both match an entry still in the queue is discarded.
- R8: A shared request whose line matches a queued exclusive entry is discarded.
- R9: Entries are issued strictly in arrival order. While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_line` and `mem_excl` hold steady.
- R10: An entry is freed at the clock edge where its memory handshake completes. A drained queue leaves `mem_valid` low and `pf_ready` high.
- R11: A memory handshake, an upgrade of another entry and the acceptance of a new request can take place in the same cycle without disturbing one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pf_valid | input | 1 | Prefetch request present |
| pf_ready | output | 1 | Block can accept a request |
| pf_addr | input | ADDR_W | Byte address of the prefetch |
| pf_excl | input | 1 | 1 = exclusive, 0 = shared |
| tag_lookup | output | 1 | Tag lookup strobe toward the primary cache |
| tag_line | output | ADDR_W-log2(LINE_BYTES) | Line address to look up |
| tag_hit | input | 1 | Lookup result, one cycle after `tag_lookup` |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the offered entry |
| mem_excl | output | 1 | Kind of the offered entry |

## Verification
The assertions assume that `tag_hit` is meaningful only in the cycle right after a `tag_lookup`. They also assume that the processor keeps `pf_addr` and `pf_excl` steady while its request waits for `pf_ready`. The bench's cache model produces `tag_hit` from a register loaded on the lookup edge, with a fixed rule on the line bits. The bench holds each request until the ready sample shows acceptance. `mem_ready` is left free and may drop at any time. The bench parks it low to build backlogs and raises it in the same cycle as an upgrade, so the hold and free properties are exercised under both states.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   // Outcome of the second stage for one request
   typedef enum logic [2:0] {
      ACT_IDLE    = 3'd0,
      ACT_HIT     = 3'd1,
      ACT_MERGE   = 3'd2,
      ACT_UPGRADE = 3'd3,
      ACT_ALLOC   = 3'd4
   } pfb_act_e;

endpackage

// File: rtl/pfb_lookup.sv
// Request pipeline: the acceptance cycle launches the tag lookup, the
// following cycle holds the request while the tag answer arrives.
module pfb_lookup #(
   parameter int unsigned LINE_W = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_fire,
   input  logic [LINE_W-1:0] req_line,
   input  logic              req_excl,
   output logic              s2_valid,
   output logic [LINE_W-1:0] s2_line,
   output logic              s2_excl
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
      end else begin
         s2_valid <= req_fire;
      end
   end

   always_ff @(posedge clk) begin
      if (req_fire) begin
         s2_line <= req_line;
         s2_excl <= req_excl;
      end
   end

endmodule

// File: rtl/pfb_match.sv
// Compares the resolved request against every queued entry and picks
// one action: drop on hit, merge, upgrade in place, or allocate.
module pfb_match
   import pfb_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LINE_W = 27,
   parameter int unsigned PW     = 3
) (
   input  logic              s2_valid,
   input  logic [LINE_W-1:0] s2_line,
   input  logic              s2_excl,
   input  logic              tag_hit,
   input  logic [DEPTH-1:0]  ent_vld,
   input  logic [DEPTH-1:0]  ent_sent,
   input  logic [DEPTH-1:0]  ent_excl,
   input  logic [LINE_W-1:0] ent_line [DEPTH],
   input  logic [PW-1:0]     head_ptr,
   output pfb_act_e          act,
   output logic [PW-1:0]     upg_idx
);

   logic [DEPTH-1:0] same;
   logic [DEPTH-1:0] locked;
   logic [DEPTH-1:0] open_shared;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign same[i]        = ent_vld[i] && (ent_line[i] == s2_line);
      // the head entry is on the memory port, so its payload is frozen
      assign locked[i]      = ent_sent[i] || (head_ptr == PW'(i));
      assign open_shared[i] = same[i] && !ent_excl[i] && !locked[i];
   end

   logic any_excl;
   logic any_shared;
   logic any_open;

   assign any_excl   = |(same & ent_excl);
   assign any_shared = |(same & ~ent_excl);
   assign any_open   = |open_shared;

   always_comb begin
      upg_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (open_shared[i]) upg_idx = PW'(i);
      end
   end

   always_comb begin
      if (!s2_valid)                  act = ACT_IDLE;
      else if (tag_hit)               act = ACT_HIT;
      else if (any_excl)              act = ACT_MERGE;
      else if (s2_excl && any_open)   act = ACT_UPGRADE;
      else if (!s2_excl && any_shared) act = ACT_MERGE;
      else                            act = ACT_ALLOC;
   end

endmodule

// File: rtl/pfb_store.sv
// Circular entry store with in-order issue over valid/ready.
module pfb_store #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LINE_W = 27,
   parameter int unsigned PW     = 3,
   parameter int unsigned CW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [LINE_W-1:0] alloc_line,
   input  logic              alloc_excl,
   input  logic              upg,
   input  logic [PW-1:0]     upg_idx,
   input  logic              mem_ready,
   output logic [DEPTH-1:0]  ent_vld,
   output logic [DEPTH-1:0]  ent_sent,
   output logic [DEPTH-1:0]  ent_excl,
   output logic [LINE_W-1:0] ent_line [DEPTH],
   output logic [PW-1:0]     head_ptr,
   output logic [CW-1:0]     occ,
   output logic              mem_valid,
   output logic [LINE_W-1:0] mem_line,
   output logic              mem_excl
);

   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;
   logic [CW-1:0] occ_q;
   logic          fire;

   assign mem_valid = ent_vld[rd_ptr];
   assign mem_line  = ent_line[rd_ptr];
   assign mem_excl  = ent_excl[rd_ptr];
   assign fire      = mem_valid && mem_ready;
   assign head_ptr  = rd_ptr;
   assign occ       = occ_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              v_q;
      logic              s_q;
      logic              x_q;
      logic [LINE_W-1:0] l_q;
      logic              wr_here;
      logic              rd_here;

      assign wr_here = alloc && (wr_ptr == PW'(i));
      assign rd_here = rd_ptr == PW'(i);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
         end else if (wr_here) begin
            v_q <= 1'b1;
            s_q <= 1'b0;
         end else if (rd_here && fire) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
         end else if (rd_here && v_q) begin
            s_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_here) begin
            x_q <= alloc_excl;
            l_q <= alloc_line;
         end else if (upg && (upg_idx == PW'(i))) begin
            x_q <= 1'b1;
         end
      end

      assign ent_vld[i]  = v_q;
      assign ent_sent[i] = s_q;
      assign ent_excl[i] = x_q;
      assign ent_line[i] = l_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ_q  <= '0;
      end else begin
         if (alloc) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         if (fire)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
         occ_q <= occ_q + CW'(alloc) - CW'(fire);
      end
   end

endmodule

// File: rtl/pf_issue_buf.sv
module pf_issue_buf
   import pfb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned DEPTH      = 8,
   localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
   localparam int unsigned LINE_W    = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pf_valid,
   output logic              pf_ready,
   input  logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_excl,
   output logic              tag_lookup,
   output logic [LINE_W-1:0] tag_line,
   input  logic              tag_hit,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [LINE_W-1:0] mem_line,
   output logic              mem_excl
);

   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pf_issue_buf: DEPTH must be at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("pf_issue_buf: LINE_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("pf_issue_buf: ADDR_W must exceed the line offset width");
   end

   logic              req_fire;
   logic              s2_valid;
   logic [LINE_W-1:0] s2_line;
   logic              s2_excl;
   logic [DEPTH-1:0]  ent_vld;
   logic [DEPTH-1:0]  ent_sent;
   logic [DEPTH-1:0]  ent_excl;
   logic [LINE_W-1:0] ent_line [DEPTH];
   logic [PW-1:0]     head_ptr;
   logic [CW-1:0]     occ;
   pfb_act_e          act;
   logic [PW-1:0]     upg_idx;
   logic              alloc;
   logic              upg;
   logic              unused_offset;

   assign unused_offset = ^pf_addr[OFF_W-1:0];

   // a request awaiting its tag answer holds a reserved slot
   assign pf_ready   = ({1'b0, occ} + {{CW{1'b0}}, s2_valid}) < (CW + 1)'(DEPTH);
   assign req_fire   = pf_valid && pf_ready;
   assign tag_lookup = req_fire;
   assign tag_line   = pf_addr[ADDR_W-1:OFF_W];

   assign alloc = act == ACT_ALLOC;
   assign upg   = act == ACT_UPGRADE;

   pfb_lookup #(.LINE_W(LINE_W)) u_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .req_line (tag_line),
      .req_excl (pf_excl),
      .s2_valid (s2_valid),
      .s2_line  (s2_line),
      .s2_excl  (s2_excl)
   );

   pfb_match #(.DEPTH(DEPTH), .LINE_W(LINE_W), .PW(PW)) u_match (
      .s2_valid (s2_valid),
      .s2_line  (s2_line),
      .s2_excl  (s2_excl),
      .tag_hit  (tag_hit),
      .ent_vld  (ent_vld),
      .ent_sent (ent_sent),
      .ent_excl (ent_excl),
      .ent_line (ent_line),
      .head_ptr (head_ptr),
      .act      (act),
      .upg_idx  (upg_idx)
   );

   pfb_store #(.DEPTH(DEPTH), .LINE_W(LINE_W), .PW(PW), .CW(CW)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc),
      .alloc_line (s2_line),
      .alloc_excl (s2_excl),
      .upg        (upg),
      .upg_idx    (upg_idx),
      .mem_ready  (mem_ready),
      .ent_vld    (ent_vld),
      .ent_sent   (ent_sent),
      .ent_excl   (ent_excl),
      .ent_line   (ent_line),
      .head_ptr   (head_ptr),
      .occ        (occ),
      .mem_valid  (mem_valid),
      .mem_line   (mem_line),
      .mem_excl   (mem_excl)
   );

endmodule

// File: rtl/pf_issue_buf_chk.sv
module pf_issue_buf_chk #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LINE_W = 27,
   parameter int unsigned CW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pf_ready,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [LINE_W-1:0] mem_line,
   input logic              mem_excl,
   input logic [CW-1:0]     occ,
   input logic              alloc
);

   // R1
   rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!mem_valid && pf_ready));

   // R4
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CW'(DEPTH)) |-> !pf_ready);

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (occ < CW'(DEPTH)));

   // R9
   hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_line) && $stable(mem_excl)));

   // R10
   free_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready && !alloc) |=> (occ == $past(occ) - CW'(1)));

   // R10
   empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> !mem_valid);

endmodule

bind pf_issue_buf pf_issue_buf_chk #(
   .DEPTH  (DEPTH),
   .LINE_W (LINE_W),
   .CW     (CW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pf_ready  (pf_ready),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_line  (mem_line),
   .mem_excl  (mem_excl),
   .occ       (occ),
   .alloc     (alloc)
);

// File: tb/pf_issue_buf_tb.sv
`timescale 1ns/1ps
module pf_issue_buf_tb;

   localparam int AW = 16;
   localparam int LB = 16;
   localparam int D  = 4;
   localparam int OW = 4;
   localparam int LW = AW - OW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          pf_valid;
   logic          pf_ready;
   logic [AW-1:0] pf_addr;
   logic          pf_excl;
   logic          tag_lookup;
   logic [LW-1:0] tag_line;
   logic          tag_hit = 1'b0;
   logic          mem_valid;
   logic          mem_ready;
   logic [LW-1:0] mem_line;
   logic          mem_excl;

   int checks = 0;
   int errors = 0;
   logic [LW:0] log_q[$];
   logic [LW:0] exp_q[$];

   always #2.5 clk = ~clk;

   pf_issue_buf #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready),
      .pf_addr(pf_addr), .pf_excl(pf_excl), .tag_lookup(tag_lookup),
      .tag_line(tag_line), .tag_hit(tag_hit), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_line(mem_line), .mem_excl(mem_excl)
   );

   // cache model: lines whose low three bits are all ones are resident
   always @(posedge clk) tag_hit <= tag_lookup && (tag_line[2:0] == 3'd7);

   // memory side log, sampled mid-cycle before the completing edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && mem_valid && mem_ready) log_q.push_back({mem_excl, mem_line});
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [LW-1:0] ln, input logic [OW-1:0] off, input logic ex);
      pf_valid = 1'b1;
      pf_addr  = {ln, off};
      pf_excl  = ex;
      @(negedge clk);
      while (!pf_ready) @(negedge clk);
      // R2 R3: lookup issued with the offset stripped
      chk(tag_lookup && tag_line == ln, "R2", "tag_line", int'(tag_line), int'(ln));
      @(posedge clk);
      #1;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drain();
      pf_valid  = 1'b0;
      mem_ready = 1'b1;
      cycles(14);
      mem_ready = 1'b0;
      cycles(1);
   endtask

   function automatic void ex(input logic [LW-1:0] ln, input logic x);
      exp_q.push_back({x, ln});
   endfunction

   task automatic expect_log(input string req);
      chk(log_q.size() == exp_q.size(), req, "issue count", log_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < log_q.size(); i++) begin
         chk(log_q[i] == exp_q[i], req, "issue entry", int'(log_q[i]), int'(exp_q[i]));
      end
      log_q.delete();
      exp_q.delete();
   endtask

   initial begin
      #(200000 * 5.0);
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pf_valid = 1'b0; pf_addr = '0; pf_excl = 1'b0; mem_ready = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!mem_valid, "R1", "mem_valid", int'(mem_valid), 0);
      chk(pf_ready, "R1", "pf_ready", int'(pf_ready), 1);
      @(posedge clk); #1;

      // R5: upgrade of a waiting, non-head shared entry
      send(12'h010, 4'h0, 1'b0);
      send(12'h011, 4'h3, 1'b0);
      send(12'h011, 4'h9, 1'b1);
      drain();
      ex(12'h010, 1'b0); ex(12'h011, 1'b1);
      expect_log("R5");

      // R6: head already on the memory port, exclusive gets its own entry
      send(12'h020, 4'h1, 1'b0);
      pf_valid = 1'b0;
      cycles(2);
      send(12'h020, 4'h2, 1'b1);
      drain();
      ex(12'h020, 1'b0); ex(12'h020, 1'b1);
      expect_log("R6");

      // R7 R8: redundant requests discarded
      send(12'h031, 4'h0, 1'b1);
      send(12'h031, 4'h4, 1'b0);
      send(12'h031, 4'h8, 1'b1);
      send(12'h032, 4'h0, 1'b0);
      send(12'h032, 4'h5, 1'b0);
      drain();
      ex(12'h031, 1'b1); ex(12'h032, 1'b0);
      expect_log("R7 R8");

      // R3: a tag hit never reaches memory
      send(12'h027, 4'h0, 1'b1);
      send(12'h030, 4'h0, 1'b0);
      drain();
      ex(12'h030, 1'b0);
      expect_log("R3");

      // R4 R9 R10: fill, stall, hold, drain in order
      for (int i = 0; i < D; i++) send(12'h040 + LW'(i), 4'h0, 1'b0);
      pf_valid = 1'b0;
      cycles(1);
      @(negedge clk);
      chk(!pf_ready, "R4", "pf_ready when full", int'(pf_ready), 0);
      chk(mem_valid && mem_line == 12'h040, "R9", "held head line", int'(mem_line), 'h40);
      @(posedge clk); #1;
      @(negedge clk);
      chk(mem_valid && mem_line == 12'h040, "R9", "head still held", int'(mem_line), 'h40);
      @(posedge clk); #1;
      mem_ready = 1'b1;
      send(12'h044, 4'h0, 1'b0);
      drain();
      for (int i = 0; i <= D; i++) ex(12'h040 + LW'(i), 1'b0);
      expect_log("R4 R9");
      @(negedge clk);
      chk(pf_ready, "R10", "pf_ready after drain", int'(pf_ready), 1);
      chk(!mem_valid, "R10", "mem_valid after drain", int'(mem_valid), 0);
      @(posedge clk); #1;

      // R11: issue of the head and upgrade of another entry in one cycle
      send(12'h050, 4'h0, 1'b0);
      send(12'h051, 4'h0, 1'b0);
      send(12'h052, 4'h0, 1'b0);
      send(12'h051, 4'h6, 1'b1);
      mem_ready = 1'b1;
      send(12'h053, 4'h0, 1'b0);
      drain();
      ex(12'h050, 1'b0); ex(12'h051, 1'b1); ex(12'h052, 1'b0); ex(12'h053, 1'b0);
      expect_log("R11");

      // R5 R6 R7 R8 sweep: two requests to one line, with or without a head ahead
      for (int h = 0; h < 2; h++) begin
         for (int t1 = 0; t1 < 2; t1++) begin
            for (int t2 = 0; t2 < 2; t2++) begin
               logic [LW-1:0] ln;
               ln = 12'h100 + LW'((h * 4 + t1 * 2 + t2) * 2);
               if (h == 1) begin
                  send(12'h0F0, 4'h0, 1'b0);
                  ex(12'h0F0, 1'b0);
               end
               send(ln, 4'h2, t1[0]);
               send(ln, 4'hB, t2[0]);
               drain();
               if (h == 0 && t1 == 0 && t2 == 1) begin
                  ex(ln, 1'b0); ex(ln, 1'b1);
               end else begin
                  ex(ln, t1[0] | t2[0]);
               end
               expect_log("R5 R6 R7 R8 sweep");
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule